// File: doc/BRIEF.md
# Vector Condition-Field Fail-First Truncator

This block walks the elements of a vectorised condition-register operation, one element per clock, and decides where the vector length is cut. For each element the surrounding pipeline presents the result the condition operation produced. The block picks one bit of that result, compares it with an invert flag, and stops at the first element whose bit does not match. It then reports the new vector length and pulses a done flag.

Two result kinds are handled. A whole 4-bit condition field is one kind, and a 2-bit selector names the bit to test. A single condition bit is the other kind, and it is tested as delivered. A keep flag decides whether the element that failed stays inside the shortened vector or is cut off with the elements after it. Each element that ends up inside the final length is reported as stored. Nothing past the cut is reported.

The controller captures the vector length and the mode fields on a start strobe. It puts the index of the element it wants on `elem_idx` and samples `elem_res` for that index at the next rising edge.

Top module: `vcrff_trunc`

## Requirements
- R1: While reset is high and in the cycle after it is released, `done`, `busy` and `store_ok` are low and `vl_out` is zero.
- R2: A `start` seen while idle captures `vl_in` (0 to MAX_VL) and the mode inputs. If the length is nonzero, `busy` rises in the next cycle with `elem_idx` = 0, and the index then rises by one per clock through `vl_in`-1.
- R3: With `single_bit` = 0 the tested bit is `elem_res[bit_sel]`, where selector values 0, 1, 2 and 3 name result bits 0, 1, 2 and 3.
- R4: With `single_bit` = 1 the tested bit is `elem_res[0]`, and `bit_sel` has no effect.
- R5: Only `mode_sel` = 2'b01 enables the test, and an element fails when its tested bit differs from `inv`. The codes 2'b00, 2'b10 and 2'b11 never truncate.
- R6: When element i fails, `done` pulses in the cycle after element i was presented. `vl_out` is then i+1 when `keep_fail` = 1 and i when `keep_fail` = 0.
- R7: When no element fails, `done` pulses `vl_in`+1 cycles after the start cycle and `vl_out` equals the captured length.
- R8: A start with `vl_in` = 0 gives `done` in the very next cycle with `vl_out` = 0.
- R9: One cycle after each element that lies inside the final length, `store_ok` is high and `store_idx` holds that element's index. A failing element is reported only when `keep_fail` = 1, and no element after a failure is reported.
- R10: `done` lasts one cycle and `busy` is low while it is high. `vl_out` holds until the next `done`.
- R11: A `start` while `busy` is high is ignored. The run in progress keeps its captured length and mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (honoured only while idle) |
| vl_in | input | VLW | Vector length to process |
| mode_sel | input | 2 | Mode code; 2'b01 enables the fail-first test |
| single_bit | input | 1 | 1: single-bit result on elem_res[0]; 0: 4-bit field result |
| bit_sel | input | 2 | Bit of the field result to test |
| inv | input | 1 | Value the tested bit must equal to pass |
| keep_fail | input | 1 | 1: the failing element stays inside the new length |
| elem_res | input | 4 | Result of the element named by elem_idx |
| busy | output | 1 | A run is in progress |
| elem_idx | output | IW | Index of the element currently requested |
| store_ok | output | 1 | The element in store_idx lies within the final length |
| store_idx | output | IW | Index reported with store_ok |
| done | output | 1 | One-cycle pulse when the new length is valid |
| vl_out | output | VLW | Resulting vector length |

## Verification
The bench puts a failing element in the middle of a field-result vector and runs it twice, once with the keep flag set and once with it clear. This separates the two truncation lengths and shows whether the failing element is reported as stored. It moves the failing bit across all four selector values, so a stuck or mis-wired selector is caught. A single-bit case is built whose field bit would pass but whose bit 0 fails, which shows that bit 0 is the bit tested. Further cases cover vectors that never fail, of full and of zero length, a failure on the last element, the three non-enabling mode codes applied to failing data, and a second start arriving mid-run. Each of these shows up in the stored-index sequence, the final length, or the cycle count to done.

// File: rtl/vcrff_pkg.sv
package vcrff_pkg;
  localparam int CR_W  = 4;
  localparam int SEL_W = $clog2(CR_W);

  localparam logic [1:0] MODE_FFIRST = 2'b01;

  typedef struct packed {
    logic [1:0]       mode;
    logic             single;
    logic [SEL_W-1:0] sel;
    logic             inv;
    logic             keep;
  } run_cfg_t;
endpackage

// File: rtl/vcrff_pick.sv
module vcrff_pick
  import vcrff_pkg::*;
(
  input  logic [1:0]       mode,
  input  logic             single,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  input  logic [CR_W-1:0]  res,
  output logic             fail
);
  logic tested;

  always_comb begin
    if (single) tested = res[0];
    else        tested = res[sel];
    fail = (mode == MODE_FFIRST) && (tested != inv);
  end
endmodule

// File: rtl/vcrff_walk.sv
module vcrff_walk
  import vcrff_pkg::*;
#(
  parameter int VLW = 7,
  parameter int IW  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  run_cfg_t       cfg_in,
  input  logic           fail,
  output logic           busy,
  output logic [IW-1:0]  idx,
  output logic [VLW-1:0] vl_q,
  output run_cfg_t       cfg_q,
  output logic           at_last,
  output logic           zero_start
);
  logic take;

  always_comb begin
    take       = start && !busy;
    zero_start = take && (vl_in == '0);
    at_last    = (VLW'(idx) + VLW'(1)) == vl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      idx   <= '0;
      vl_q  <= '0;
      cfg_q <= '0;
    end else if (take) begin
      vl_q  <= vl_in;
      cfg_q <= cfg_in;
      idx   <= '0;
      busy  <= (vl_in != '0);
    end else if (busy) begin
      if (fail || at_last) busy <= 1'b0;
      else                 idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/vcrff_report.sv
module vcrff_report #(
  parameter int VLW = 7,
  parameter int IW  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           busy,
  input  logic [IW-1:0]  idx,
  input  logic           fail,
  input  logic           at_last,
  input  logic           keep,
  input  logic [VLW-1:0] vl_q,
  input  logic           zero_start,
  output logic           done,
  output logic [VLW-1:0] vl_out,
  output logic           store_ok,
  output logic [IW-1:0]  store_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      vl_out    <= '0;
      store_ok  <= 1'b0;
      store_idx <= '0;
    end else begin
      done     <= 1'b0;
      store_ok <= 1'b0;
      if (zero_start) begin
        done   <= 1'b1;
        vl_out <= '0;
      end else if (busy) begin
        store_ok  <= !fail || keep;
        store_idx <= idx;
        if (fail) begin
          done   <= 1'b1;
          vl_out <= keep ? VLW'(idx) + VLW'(1) : VLW'(idx);
        end else if (at_last) begin
          done   <= 1'b1;
          vl_out <= vl_q;
        end
      end
    end
  end
endmodule

// File: rtl/vcrff_trunc.sv
module vcrff_trunc
  import vcrff_pkg::*;
#(
  parameter int MAX_VL = 64,
  localparam int VLW   = $clog2(MAX_VL + 1),
  localparam int IW    = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VLW-1:0]    vl_in,
  input  logic [1:0]        mode_sel,
  input  logic              single_bit,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              inv,
  input  logic              keep_fail,
  input  logic [CR_W-1:0]   elem_res,
  output logic              busy,
  output logic [IW-1:0]     elem_idx,
  output logic              store_ok,
  output logic [IW-1:0]     store_idx,
  output logic              done,
  output logic [VLW-1:0]    vl_out
);
  run_cfg_t       cfg_in, cfg_q;
  logic           fail, at_last, zero_start;
  logic [VLW-1:0] vl_q;

  always_comb begin
    cfg_in.mode   = mode_sel;
    cfg_in.single = single_bit;
    cfg_in.sel    = bit_sel;
    cfg_in.inv    = inv;
    cfg_in.keep   = keep_fail;
  end

  vcrff_pick u_pick (
    .mode   (cfg_q.mode),
    .single (cfg_q.single),
    .sel    (cfg_q.sel),
    .inv    (cfg_q.inv),
    .res    (elem_res),
    .fail   (fail)
  );

  vcrff_walk #(.VLW(VLW), .IW(IW)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .vl_in      (vl_in),
    .cfg_in     (cfg_in),
    .fail       (fail),
    .busy       (busy),
    .idx        (elem_idx),
    .vl_q       (vl_q),
    .cfg_q      (cfg_q),
    .at_last    (at_last),
    .zero_start (zero_start)
  );

  vcrff_report #(.VLW(VLW), .IW(IW)) u_report (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .idx        (elem_idx),
    .fail       (fail),
    .at_last    (at_last),
    .keep       (cfg_q.keep),
    .vl_q       (vl_q),
    .zero_start (zero_start),
    .done       (done),
    .vl_out     (vl_out),
    .store_ok   (store_ok),
    .store_idx  (store_idx)
  );
endmodule

// File: rtl/vcrff_trunc_chk.sv
module vcrff_trunc_chk #(
  parameter int VLW = 7,
  parameter int IW  = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [VLW-1:0] vl_in,
  input logic           busy,
  input logic [IW-1:0]  elem_idx,
  input logic           done,
  input logic [VLW-1:0] vl_out,
  input logic           store_ok
);
  logic [VLW-1:0] vl_cap;

  always_ff @(posedge clk) begin
    if (rst)                 vl_cap <= '0;
    else if (start && !busy) vl_cap <= vl_in;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                        // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);                                        // R10
  AST_IDX_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> elem_idx == '0);                        // R2
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> elem_idx == IW'($past(elem_idx) + 1'b1)); // R2
  AST_NO_LATE_STORE: assert property (@(posedge clk) disable iff (rst)
    done |=> !store_ok);                                    // R9
  AST_VL_BOUND: assert property (@(posedge clk) disable iff (rst)
    done |-> vl_out <= vl_cap);                             // R6
endmodule

bind vcrff_trunc vcrff_trunc_chk #(.VLW(VLW), .IW(IW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .vl_in    (vl_in),
  .busy     (busy),
  .elem_idx (elem_idx),
  .done     (done),
  .vl_out   (vl_out),
  .store_ok (store_ok)
);

// File: tb/vcrff_trunc_test.sv
`timescale 1ns/1ps
module vcrff_trunc_test;
  localparam int MAX_VL = 64;
  localparam int VLW = $clog2(MAX_VL + 1);
  localparam int IW  = $clog2(MAX_VL);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [VLW-1:0] vl_in = '0;
  logic [1:0] mode_sel = 2'b01;
  logic single_bit = 1'b0;
  logic [1:0] bit_sel = '0;
  logic inv = 1'b0;
  logic keep_fail = 1'b0;
  logic [3:0] elem_res = '0;
  logic busy, store_ok, done;
  logic [IW-1:0] elem_idx, store_idx;
  logic [VLW-1:0] vl_out;

  logic [3:0] mem [MAX_VL];
  int exp_store[$];
  int exp_vl[$];
  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vcrff_trunc #(.MAX_VL(MAX_VL)) uut (
    .clk(clk), .rst(rst), .start(start), .vl_in(vl_in),
    .mode_sel(mode_sel), .single_bit(single_bit), .bit_sel(bit_sel),
    .inv(inv), .keep_fail(keep_fail), .elem_res(elem_res),
    .busy(busy), .elem_idx(elem_idx), .store_ok(store_ok),
    .store_idx(store_idx), .done(done), .vl_out(vl_out)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) elem_res = mem[elem_idx];

  // monitor: pops expected items as the design reports them
  always @(negedge clk) begin
    if (!rst) begin
      if (store_ok) begin
        if (exp_store.size() == 0) check(0, "R9 unexpected store", int'(store_idx), -1);
        else begin
          int e;
          e = exp_store.pop_front();
          check(int'(store_idx) == e, "R9 store index", int'(store_idx), e);
        end
      end
      if (done) begin
        if (exp_vl.size() == 0) check(0, "R10 unexpected done", int'(vl_out), -1);
        else begin
          int v;
          v = exp_vl.pop_front();
          check(int'(vl_out) == v, "R6/R7 new length", int'(vl_out), v);
        end
      end
    end
  end

  task automatic run(input int vl, input logic [1:0] mode, input bit single,
                     input logic [1:0] sel, input bit iv, input bit keep,
                     input bit poke, input string tag);
    int nvl, lat, cnt;
    nvl = vl;
    lat = (vl == 0) ? 1 : vl + 1;
    for (int i = 0; i < vl; i++) begin
      bit t, pass;
      t = single ? mem[i][0] : mem[i][sel];
      pass = (mode != 2'b01) || (t == iv);
      if (pass) exp_store.push_back(i);
      else begin
        if (keep) exp_store.push_back(i);
        nvl = keep ? i + 1 : i;
        lat = i + 2;
        break;
      end
    end
    exp_vl.push_back(nvl);
    @(negedge clk);
    vl_in = VLW'(vl); mode_sel = mode; single_bit = single;
    bit_sel = sel; inv = iv; keep_fail = keep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 200) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 2) begin
        start = 1'b1; vl_in = VLW'(3); mode_sel = 2'b01; inv = ~iv; keep_fail = 1'b0;
      end else start = 1'b0;
    end
    start = 1'b0;
    check(cnt == lat, tag, cnt, lat);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAX_VL; i++) mem[i] = 4'b1111;
    repeat (3) @(negedge clk);
    check(!done && !busy && !store_ok && vl_out == '0, "R1 reset outputs",
          int'({done, busy, store_ok}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !busy && !store_ok && vl_out == '0, "R1 after release",
          int'(vl_out), 0);

    // R3/R6: field result, fail in the middle, keep vs drop
    for (int i = 0; i < MAX_VL; i++) mem[i] = 4'b0100;
    mem[5] = 4'b1011;
    run(8, 2'b01, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, "R6 latency keep");
    run(8, 2'b01, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, "R6 latency drop");

    // R3: each selector value
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < MAX_VL; i++) mem[i] = 4'b1111;
      mem[3] = ~(4'b0001 << s);
      run(10, 2'b01, 1'b0, 2'(s), 1'b1, 1'b1, 1'b0, "R3 selector latency");
    end

    // R4: single-bit result uses bit 0 only
    for (int i = 0; i < MAX_VL; i++) mem[i] = 4'b1110;
    mem[0] = 4'b0001;
    run(6, 2'b01, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, "R4 single fail at 0");
    mem[0] = 4'b1110;
    run(6, 2'b01, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, "R4 single no fail");

    // R7: full length, no failure
    for (int i = 0; i < MAX_VL; i++) mem[i] = 4'b1111;
    run(MAX_VL, 2'b01, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, "R7 full length latency");

    // R5: non-enabling codes on failing data
    for (int i = 0; i < MAX_VL; i++) mem[i] = 4'b0000;
    run(6, 2'b00, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, "R5 code 00");
    run(6, 2'b10, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, "R5 code 10");
    run(6, 2'b11, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, "R5 code 11");

    // R8: zero length
    run(0, 2'b01, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, "R8 zero length latency");

    // R6: failure on the last element
    for (int i = 0; i < MAX_VL; i++) mem[i] = 4'b1111;
    mem[6] = 4'b0000;
    run(7, 2'b01, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, "R6 last keep");
    run(7, 2'b01, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, "R6 last drop");

    // R11: start while busy is ignored
    for (int i = 0; i < MAX_VL; i++) mem[i] = 4'b1111;
    run(20, 2'b01, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, "R11 restart ignored");

    repeat (3) @(negedge clk);
    check(exp_store.size() == 0, "R9 missing stores", exp_store.size(), 0);
    check(exp_vl.size() == 0, "R10 missing done", exp_vl.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule